// File: doc/BRIEF.md
# Linked Descriptor Fetcher

This block runs chains of transfer descriptors for a group of DMA channels. Software writes a descriptor address into a channel, then writes a 1 to that channel's bit in the doorbell-set register. The fetcher reads the four-word descriptor from memory. It checks that the descriptor is valid, hands the command, both addresses and the count to the data-movement engine, and then waits for the engine to report that the transfer is done. If the descriptor's link bit is set, the fetcher follows the next-descriptor offset and repeats the sequence. When the chain ends, the channel's doorbell bit clears.

The data-movement engine is outside this block. A one-cycle start strobe with the loaded fields drives it, and a one-cycle done pulse answers. Memory reads use a simple request/valid port with one word outstanding. Each channel has an interrupt line that follows its pending bit. Invalid descriptors and completions can set that pending bit.

A single fetch engine is shared by all channels. It serves one chain at a time, and when several doorbells are set it takes the lowest-numbered channel first.

Top module: `desc_fetcher`

## Requirements
- R1: After reset the doorbell, pending and status registers are zero, and mem_rd, xfer_start and irq are low.
- R2: A write to address 0x30C sets doorbell bit n for each 1 in write-data bit n. Bits written as 0 are unchanged. The doorbell is read back at 0x308, and writes to 0x308 have no effect.
- R3: While status bit 31 of channel n (register at n*0x20+0x10) is 1, a doorbell-set write to bit n is ignored: the doorbell bit stays 0 and no memory read is issued.
- R4: A descriptor at address A is read as four single-word reads at A, A+4, A+8 and A+12, in that order. All four complete before xfer_start rises.
- R5: At the start strobe, xfer_ch is the channel, xfer_cmd is word 0, xfer_src is word 1, xfer_dst is word 2, and xfer_count is bits 23:0 of word 3.
- R6: A descriptor whose word 0 bit 4 is clear is invalid. It is not started, status bit 6 of the channel is set, and the doorbell bit clears. The pending bit is set only if word 0 bit 2 is 1.
- R7: When a transfer is done and word 0 bit 0 is set, the next address is {A[31:12], word3[31:24], 4'h0}. This address is stored in the channel's descriptor-address register (n*0x20+0x18) and fetched next.
- R8: When a transfer is done and word 0 bit 0 is clear, the chain ends: the doorbell bit clears and status bit 1 is set.
- R9: If word 0 bit 1 is set, each completed transfer sets the channel's pending bit (read at 0x304). irq[n] equals pending bit n. Writing a 1 to bit n of 0x304 clears it.
- R10: If several doorbells are pending when the fetcher is idle, the lowest channel's chain runs to its end before the next chain is fetched.
- R11: A doorbell-set write for a channel whose chain is already running does not restart or repeat that chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_rd | output | 1 | Descriptor read request, held until mem_rvalid |
| mem_addr | output | 32 | Descriptor word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| xfer_start | output | 1 | One-cycle start strobe to the data engine |
| xfer_ch | output | CW | Channel being started |
| xfer_cmd | output | 32 | Command word |
| xfer_src | output | 32 | Source address |
| xfer_dst | output | 32 | Target address |
| xfer_count | output | 24 | Transfer count in units |
| xfer_done | input | 1 | One-cycle transfer-done pulse |
| irq | output | NCH | Per-channel interrupt |

## Verification
Two situations are hard to reach from the ports. The first is a doorbell write that lands while the same channel's chain is already running. The bench issues the doorbell-set write partway through a three-descriptor chain and then counts the engine starts. The second is an invalid descriptor in the middle of a chain. The bench builds a valid first descriptor whose link points at an invalid one, so the failure is found only after a link is followed. It then checks that exactly one transfer started.

// File: rtl/desc_fetcher.sv
module desc_fetcher #(
  parameter int NCH = 4,
  parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [11:0]    reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           mem_rd,
  output logic [31:0]    mem_addr,
  input  logic           mem_rvalid,
  input  logic [31:0]    mem_rdata,
  output logic           xfer_start,
  output logic [CW-1:0]  xfer_ch,
  output logic [31:0]    xfer_cmd,
  output logic [31:0]    xfer_src,
  output logic [31:0]    xfer_dst,
  output logic [23:0]    xfer_count,
  input  logic           xfer_done,
  output logic [NCH-1:0] irq
);
  localparam logic [11:0] A_PEND = 12'h304;
  localparam logic [11:0] A_DB   = 12'h308;
  localparam logic [11:0] A_DBS  = 12'h30C;
  localparam logic [4:0]  O_STAT = 5'h10;
  localparam logic [4:0]  O_DAR  = 5'h18;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_CHECK, S_RUN} st_t;
  st_t state;

  logic [31:0]    dar [NCH];
  logic [NCH-1:0] nd, inv, fin, db, pend;
  logic [CW-1:0]  cur_ch;
  logic [31:0]    cur_addr;
  logic [1:0]     widx;
  logic [31:0]    dw [4];

  logic [2:0] rchf;
  logic [4:0] roff;
  logic       rin_ch;
  assign rchf   = reg_addr[7:5];
  assign roff   = reg_addr[4:0];
  assign rin_ch = (reg_addr[11:8] == 4'h0) && (32'(rchf) < NCH);

  logic [CW-1:0] sel;
  logic          found;
  always_comb begin
    sel = '0;
    found = 1'b0;
    for (int i = NCH - 1; i >= 0; i--)
      if (db[i] && !nd[i]) begin
        sel = CW'(i);
        found = 1'b1;
      end
  end

  logic [31:0] nxt;
  assign nxt = {cur_addr[31:12], dw[3][31:24], 4'h0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      nd       <= '0;
      inv      <= '0;
      fin      <= '0;
      db       <= '0;
      pend     <= '0;
      cur_ch   <= '0;
      cur_addr <= '0;
      widx     <= '0;
      for (int i = 0; i < NCH; i++) dar[i] <= '0;
      for (int k = 0; k < 4; k++) dw[k] <= '0;
    end else begin
      for (int i = 0; i < NCH; i++)
        if (reg_wr && rin_ch && 32'(rchf) == i) begin
          if (roff == O_DAR) dar[i] <= {reg_wdata[31:4], 4'h0};
          if (roff == O_STAT) begin
            nd[i]  <= reg_wdata[31];
            inv[i] <= reg_wdata[6];
            fin[i] <= reg_wdata[1];
          end
        end
      if (reg_wr && reg_addr == A_DBS) db <= db | (reg_wdata[NCH-1:0] & ~nd);
      if (reg_wr && reg_addr == A_PEND) pend <= pend & ~reg_wdata[NCH-1:0];

      case (state)
        S_IDLE: if (found) begin
          cur_ch   <= sel;
          cur_addr <= dar[sel];
          widx     <= '0;
          state    <= S_FETCH;
        end
        S_FETCH: if (mem_rvalid) begin
          dw[widx] <= mem_rdata;
          widx     <= widx + 2'd1;
          if (widx == 2'd3) state <= S_CHECK;
        end
        S_CHECK: begin
          if (!dw[0][4]) begin
            inv[cur_ch] <= 1'b1;
            db[cur_ch]  <= 1'b0;
            if (dw[0][2]) pend[cur_ch] <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_RUN;
          end
        end
        S_RUN: if (xfer_done) begin
          if (dw[0][1]) pend[cur_ch] <= 1'b1;
          if (dw[0][0]) begin
            cur_addr    <= nxt;
            dar[cur_ch] <= nxt;
            widx        <= '0;
            state       <= S_FETCH;
          end else begin
            db[cur_ch]  <= 1'b0;
            fin[cur_ch] <= 1'b1;
            state       <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_rd     = (state == S_FETCH);
  assign mem_addr   = cur_addr + {28'h0, widx, 2'b00};
  assign xfer_start = (state == S_CHECK) && dw[0][4];
  assign xfer_ch    = cur_ch;
  assign xfer_cmd   = dw[0];
  assign xfer_src   = dw[1];
  assign xfer_dst   = dw[2];
  assign xfer_count = dw[3][23:0];
  assign irq        = pend;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_PEND)    reg_rdata = 32'(pend);
    else if (reg_addr == A_DB) reg_rdata = 32'(db);
    else if (rin_ch) begin
      for (int i = 0; i < NCH; i++)
        if (32'(rchf) == i) begin
          if (roff == O_DAR)  reg_rdata = dar[i];
          if (roff == O_STAT) reg_rdata = {nd[i], 24'h0, inv[i], 4'h0, fin[i], 1'b0};
        end
    end
  end

  a_r4_start_after_last_word: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> $past(mem_rvalid));
  a_r4_no_read_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !mem_rd);
  a_r4_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> mem_addr[1:0] == 2'b00);
  a_r7_same_region: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> mem_addr[31:12] == $past(mem_addr[31:12]));
  a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq & ~$past(irq))) |-> ($past(xfer_done) || $past(state == S_CHECK)));
  a_r8_doorbell_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && xfer_done && !dw[0][0]) |=> !db[cur_ch]);
endmodule

// File: tb/sim_desc_fetcher.sv
module sim_desc_fetcher;
  localparam int NCH = 4;
  localparam int CW  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic           reg_wr = 1'b0;
  logic [11:0]    reg_addr = '0;
  logic [31:0]    reg_wdata = '0, reg_rdata;
  logic           mem_rd, mem_rvalid = 1'b0;
  logic [31:0]    mem_addr, mem_rdata = '0;
  logic           xfer_start, xfer_done = 1'b0;
  logic [CW-1:0]  xfer_ch;
  logic [31:0]    xfer_cmd, xfer_src, xfer_dst;
  logic [23:0]    xfer_count;
  logic [NCH-1:0] irq;

  desc_fetcher #(.NCH(NCH)) u0 (.*);

  int n_chk = 0, n_bad = 0;
  logic [31:0] mem [0:1023];
  logic [31:0] rd_log [0:63];
  int rd_n = 0;
  logic [CW-1:0] s_ch [0:15];
  logic [31:0] s_cmd [0:15], s_src [0:15], s_dst [0:15];
  logic [23:0] s_cnt [0:15];
  int st_n = 0;
  int eng_t = 0;

  always @(posedge clk) begin
    if (mem_rd && !mem_rvalid) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem[mem_addr[11:2]];
      if (rd_n < 64) rd_log[rd_n] <= mem_addr;
      rd_n <= rd_n + 1;
    end else mem_rvalid <= 1'b0;
  end

  always @(posedge clk) begin
    xfer_done <= 1'b0;
    if (xfer_start) begin
      if (st_n < 16) begin
        s_ch[st_n] <= xfer_ch; s_cmd[st_n] <= xfer_cmd; s_src[st_n] <= xfer_src;
        s_dst[st_n] <= xfer_dst; s_cnt[st_n] <= xfer_count;
      end
      st_n  <= st_n + 1;
      eng_t <= 3;
    end else if (eng_t > 0) begin
      eng_t <= eng_t - 1;
      if (eng_t == 1) xfer_done <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] c, input logic [31:0] s,
                          input logic [31:0] t, input logic [31:0] w3);
    mem[a[11:2]] = c; mem[a[11:2]+1] = s; mem[a[11:2]+2] = t; mem[a[11:2]+3] = w3;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(12'h308, v);
      if (v == 0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(12'h308, v); chk(v == 0, "R1 doorbell", v, 0);
    rd(12'h304, v); chk(v == 0, "R1 pending", v, 0);
    rd(12'h030, v); chk(v == 0, "R1 status ch1", v, 0);
    chk(!mem_rd && !xfer_start && irq == 0, "R1 outputs", {mem_rd, xfer_start, irq}, 0);
  endtask

  task automatic t_doorbell_regs();
    logic [31:0] v;
    wr(12'h308, 32'hF);
    rd(12'h308, v); chk(v == 0, "R2 write to doorbell ignored", v, 0);
    chk(rd_n == 0, "R2 no fetch after ignored write", rd_n, 0);
  endtask

  task automatic t_nodesc();
    logic [31:0] v;
    int b = rd_n;
    wr(12'h070, 32'h8000_0000);
    wr(12'h30C, 32'h8);
    repeat (20) @(negedge clk);
    rd(12'h308, v); chk(v == 0, "R3 doorbell stays clear", v, 0);
    chk(rd_n == b, "R3 no memory read", rd_n, b);
    wr(12'h070, 32'h0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    int b = rd_n, s = st_n;
    put_desc(32'h5300, 32'h10, 32'h1111_0000, 32'h2222_0000, 32'hAB00_0040);
    wr(12'h078, 32'h5300);
    wr(12'h30C, 32'h8);
    rd(12'h308, v); chk(v == 32'h8, "R2 doorbell set", v, 32'h8);
    wait_idle();
    chk(rd_n == b + 4, "R4 four reads", rd_n, b + 4);
    for (int k = 0; k < 4; k++)
      chk(rd_log[b+k] == 32'h5300 + 4*k, "R4 read order", rd_log[b+k], 32'h5300 + 4*k);
    chk(st_n == s + 1, "R5 one start", st_n, s + 1);
    chk(s_ch[s] == 3, "R5 channel", 32'(s_ch[s]), 3);
    chk(s_cmd[s] == 32'h10, "R5 cmd", s_cmd[s], 32'h10);
    chk(s_src[s] == 32'h1111_0000, "R5 src", s_src[s], 32'h1111_0000);
    chk(s_dst[s] == 32'h2222_0000, "R5 dst", s_dst[s], 32'h2222_0000);
    chk(s_cnt[s] == 24'h40, "R5 count", 32'(s_cnt[s]), 32'h40);
    rd(12'h070, v); chk(v == 32'h2, "R8 end flag", v, 32'h2);
    chk(irq == 0, "R9 no irq without enable", 32'(irq), 0);
    wr(12'h070, 32'h0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    int b = rd_n, s = st_n;
    put_desc(32'h5100, 32'h13, 32'hA000_0000, 32'hB000_0000, {8'h20, 24'd100});
    put_desc(32'h5200, 32'h13, 32'hA000_1000, 32'hB000_1000, {8'h08, 24'd7});
    put_desc(32'h5080, 32'h12, 32'hA000_2000, 32'hB000_2000, 32'hFFFF_FFFF);
    wr(12'h018, 32'h5100);
    wr(12'h30C, 32'h1);
    repeat (12) @(negedge clk);
    wr(12'h30C, 32'h1);
    wait_idle();
    chk(st_n == s + 3, "R11 chain not repeated", st_n, s + 3);
    chk(rd_n == b + 12, "R7 twelve reads", rd_n, b + 12);
    chk(rd_log[b+4] == 32'h5200, "R7 first link", rd_log[b+4], 32'h5200);
    chk(rd_log[b+8] == 32'h5080, "R7 second link", rd_log[b+8], 32'h5080);
    chk(s_src[s+2] == 32'hA000_2000, "R7 third descriptor src", s_src[s+2], 32'hA000_2000);
    chk(s_cnt[s+2] == 24'hFFFFFF, "R5 max count", 32'(s_cnt[s+2]), 32'hFFFFFF);
    rd(12'h018, v); chk(v == 32'h5080, "R7 address register", v, 32'h5080);
    rd(12'h010, v); chk(v == 32'h2, "R8 chain end flag", v, 32'h2);
    chk(irq == 4'b0001, "R9 irq ch0", 32'(irq), 1);
    wr(12'h304, 32'h1);
    rd(12'h304, v); chk(v == 0 && irq == 0, "R9 pending cleared", v, 0);
    wr(12'h010, 32'h0);
  endtask

  task automatic t_invalid();
    logic [31:0] v;
    int s = st_n;
    put_desc(32'h5400, 32'h05, 32'h1, 32'h2, 32'h0000_0010);
    wr(12'h038, 32'h5400);
    wr(12'h30C, 32'h2);
    wait_idle();
    chk(st_n == s, "R6 invalid not started", st_n, s);
    rd(12'h030, v); chk(v == 32'h40, "R6 invalid flag", v, 32'h40);
    chk(irq == 4'b0010, "R6 invalid irq", 32'(irq), 2);
    wr(12'h304, 32'h2);
    put_desc(32'h5500, 32'h11, 32'h3, 32'h4, {8'h60, 24'd1});
    put_desc(32'h5600, 32'h01, 32'h5, 32'h6, 32'h0);
    wr(12'h058, 32'h5500);
    wr(12'h30C, 32'h4);
    wait_idle();
    chk(st_n == s + 1, "R6 mid-chain invalid", st_n, s + 1);
    rd(12'h050, v); chk(v == 32'h40, "R6 flag mid-chain", v, 32'h40);
    chk(irq == 0, "R6 no irq without enable", 32'(irq), 0);
    rd(12'h308, v); chk(v == 0, "R6 doorbell cleared", v, 0);
  endtask

  task automatic t_priority();
    int s = st_n;
    put_desc(32'h5700, 32'h10, 32'h7, 32'h8, 32'h1);
    put_desc(32'h5800, 32'h10, 32'h9, 32'hA, 32'h1);
    wr(12'h038, 32'h5800);
    wr(12'h058, 32'h5700);
    wr(12'h30C, 32'h6);
    wait_idle();
    chk(st_n == s + 2, "R10 both served", st_n, s + 2);
    chk(s_ch[s] == 1 && s_src[s] == 32'h9, "R10 lower channel first", 32'(s_ch[s]), 1);
    chk(s_ch[s+1] == 2, "R10 higher channel second", 32'(s_ch[s+1]), 2);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_doorbell_regs();
    t_nodesc();
    t_single();
    t_chain();
    t_invalid();
    t_priority();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule